// File: doc/BRIEF.md
# Processor-Local Interrupt Unit

This block sits beside one processor core and decides which interrupt the core sees. It has two modes, chosen by an enable bit. In legacy mode the unit is transparent: two local pins go straight to the core, one as the maskable request and one as the non-maskable request. In enabled mode the pins are ignored. Interrupts then come in as messages on a valid/ready input, each message carrying a destination unit number and an 8-bit vector. The unit keeps a message when the destination is its own number or the broadcast value. Kept vectors are stored in a 256-entry pending bitmap. The highest pending vector is offered to the core, but only when its priority class is above the class of the task priority register. The core takes the offered vector by pulsing an acknowledge, which retires that vector.

Software also uses the command register to send an inter-processor interrupt. Writing a vector and a target number starts one outgoing message. The message stays on the output handshake until it is accepted. While it waits, a busy bit in the same register reads 1.

The core delivery path is a two-state machine. DLV_IDLE goes to DLV_OFFER when the unit is enabled and a qualifying vector is pending. DLV_OFFER goes back to DLV_IDLE on acknowledge or when the unit is disabled. The sender is a second two-state machine. SND_IDLE goes to SND_BUSY on a command write. SND_BUSY goes back to SND_IDLE when the output message is accepted.

Top module: `core_irq_unit`

## Requirements
- R1: After reset the unit is in legacy mode. Its number, task priority, enable bit, command fields and busy bit all read 0, nothing is pending, and `msg_out_valid` is 0.
- R2: While the enable bit (register 2, bit 0) is 0, `core_intr` equals `pin_intr`, `core_nmi` equals `pin_nmi` and `core_vector` is 0 in the same cycle. Messages received in this mode are discarded and never offered later.
- R3: While enabled, both local pins have no effect, and `core_nmi` is 0.
- R4: While enabled, an incoming message is recorded only if its destination equals the unit number (register 0, bits 7:0) or is the broadcast value 8'hFF. Any other message is discarded.
- R5: A pending vector is offered only when its class (vector bits 7:4) is strictly greater than the task priority class (register 1, bits 7:4). A gated vector stays pending and is offered once the task priority drops.
- R6: When several qualifying vectors are pending, the numerically highest is offered first.
- R7: An offer starts one cycle after the vector qualifies. `core_intr` then stays 1 with `core_vector` unchanged until `core_ack`. The acknowledge edge clears that vector's pending bit, and `core_intr` is 0 for the next cycle.
- R8: Register map on `reg_addr`: 0 is the unit number, 1 is the task priority, 2 is the enable bit, 3 is the command register. `reg_rdata` shows the selected register combinationally, and unused bits read 0.
- R9: A write to register 3 while idle stores vector bits 7:0 and target bits 15:8, and raises `msg_out_valid` on the next cycle with those values. Bit 16 reads 1 until the edge where `msg_out_ready` is high, and then reads 0.
- R10: A write to register 3 while a message is waiting is ignored. The stored fields and the outgoing message do not change.
- R11: While `msg_out_valid` is 1 and `msg_out_ready` is 0, the outgoing target and vector stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| msg_in_valid | input | 1 | Incoming interrupt message present |
| msg_in_ready | output | 1 | Incoming message taken (always 1) |
| msg_in_dest | input | 8 | Destination number of the incoming message |
| msg_in_vector | input | 8 | Vector of the incoming message |
| msg_out_valid | output | 1 | Outgoing inter-processor message present |
| msg_out_ready | input | 1 | Outgoing message accepted |
| msg_out_dest | output | 8 | Target number of the outgoing message |
| msg_out_vector | output | 8 | Vector of the outgoing message |
| pin_intr | input | 1 | Local pin used as maskable request in legacy mode |
| pin_nmi | input | 1 | Local pin used as non-maskable request in legacy mode |
| core_intr | output | 1 | Maskable interrupt request to the core |
| core_nmi | output | 1 | Non-maskable interrupt request to the core |
| core_vector | output | 8 | Vector offered to the core |
| core_ack | input | 1 | Core takes the offered vector |

## Verification
A stale or corrupted pending bit shows up at the ports as a missing offer or an extra one. It also breaks the order in which vectors appear on `core_vector` after each acknowledge, and this shows within two cycles of the acknowledge. A wrong delivery state shows as `core_intr` staying high after an acknowledge, or as the vector changing while it is offered. A wrong sender state shows as a busy bit or a `msg_out_valid` that disagrees with the handshake on the very next cycle. The bench keeps an independent model of these outputs and compares them, together with the read-back of every register, on each clock. Most faults are therefore caught within one or two cycles of their cause.

// File: rtl/irqu_pkg.sv
package irqu_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_ID   = 2'd0,
        RA_PRIO = 2'd1,
        RA_CTRL = 2'd2,
        RA_CMD  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        DLV_IDLE  = 1'b0,
        DLV_OFFER = 1'b1
    } dlv_state_e;

    typedef enum logic {
        SND_IDLE = 1'b0,
        SND_BUSY = 1'b1
    } snd_state_e;

endpackage

// File: rtl/irqu_regs.sv
module irqu_regs
    import irqu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 8,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [VEC_W-1:0]  cmd_vec,
    input  logic [ID_W-1:0]   cmd_dest,
    input  logic              cmd_busy,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [ID_W-1:0]   unit_id,
    output logic [VEC_W-1:0]  prio,
    output logic              enable,
    output logic              cmd_launch,
    output logic [VEC_W-1:0]  wr_vec,
    output logic [ID_W-1:0]   wr_dest
);
    localparam int BUSY_POS = VEC_W + ID_W;

    logic unused_hi;
    assign unused_hi = ^reg_wdata[DATA_W-1:BUSY_POS];

    assign wr_vec     = reg_wdata[VEC_W-1:0];
    assign wr_dest    = reg_wdata[VEC_W +: ID_W];
    assign cmd_launch = reg_we && (reg_addr == RA_CMD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_id <= '0;
            prio    <= '0;
            enable  <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                RA_ID:   unit_id <= reg_wdata[ID_W-1:0];
                RA_PRIO: prio    <= reg_wdata[VEC_W-1:0];
                RA_CTRL: enable  <= reg_wdata[0];
                RA_CMD:  ;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_ID:   reg_rdata[ID_W-1:0]  = unit_id;
            RA_PRIO: reg_rdata[VEC_W-1:0] = prio;
            RA_CTRL: reg_rdata[0]         = enable;
            RA_CMD: begin
                reg_rdata[VEC_W-1:0]   = cmd_vec;
                reg_rdata[VEC_W +: ID_W] = cmd_dest;
                reg_rdata[BUSY_POS]    = cmd_busy;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqu_pending.sv
module irqu_pending #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_vec,
    output logic             top_valid,
    output logic [VEC_W-1:0] top_vec
);
    localparam int NVEC = 1 << VEC_W;

    logic [NVEC-1:0] pend_q;

    // clear first, then set: a fresh arrival of the retired vector survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            if (clr_en) pend_q[clr_vec] <= 1'b0;
            if (set_en) pend_q[set_vec] <= 1'b1;
        end
    end

    // highest set index wins: later iterations overwrite earlier ones
    always_comb begin
        top_valid = 1'b0;
        top_vec   = '0;
        for (int i = 0; i < NVEC; i++) begin
            if (pend_q[i]) begin
                top_valid = 1'b1;
                top_vec   = VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqu_deliver.sv
module irqu_deliver
    import irqu_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [CLASS_W-1:0] prio_class,
    input  logic               top_valid,
    input  logic [VEC_W-1:0]   top_vec,
    input  logic               core_ack,
    output logic               offer,
    output logic [VEC_W-1:0]   offer_vec,
    output logic               clr_en,
    output logic [VEC_W-1:0]   clr_vec
);
    dlv_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             qualify;

    assign qualify = top_valid && (top_vec[VEC_W-1 -: CLASS_W] > prio_class);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLV_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DLV_IDLE && state_d == DLV_OFFER) vec_q <= top_vec;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_IDLE:  if (enable && qualify)    state_d = DLV_OFFER;
            DLV_OFFER: if (!enable || core_ack)  state_d = DLV_IDLE;
            default:                             state_d = DLV_IDLE;
        endcase
    end

    always_comb begin
        offer     = (state_q == DLV_OFFER);
        offer_vec = vec_q;
        clr_en    = (state_q == DLV_OFFER) && enable && core_ack;
        clr_vec   = vec_q;
    end

endmodule

// File: rtl/irqu_sender.sv
module irqu_sender
    import irqu_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic [ID_W-1:0]  wr_dest,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic [ID_W-1:0]  out_dest,
    output logic             busy
);
    snd_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [ID_W-1:0]  dest_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SND_IDLE;
            vec_q   <= '0;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SND_IDLE && launch) begin
                vec_q  <= wr_vec;
                dest_q <= wr_dest;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SND_IDLE: if (launch)    state_d = SND_BUSY;
            SND_BUSY: if (out_ready) state_d = SND_IDLE;
            default:                 state_d = SND_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q == SND_BUSY);
        busy      = (state_q == SND_BUSY);
        out_vec   = vec_q;
        out_dest  = dest_q;
    end

endmodule

// File: rtl/core_irq_unit.sv
module core_irq_unit
    import irqu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ID_W    = 8,
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              msg_in_valid,
    output logic              msg_in_ready,
    input  logic [ID_W-1:0]   msg_in_dest,
    input  logic [VEC_W-1:0]  msg_in_vector,
    output logic              msg_out_valid,
    input  logic              msg_out_ready,
    output logic [ID_W-1:0]   msg_out_dest,
    output logic [VEC_W-1:0]  msg_out_vector,
    input  logic              pin_intr,
    input  logic              pin_nmi,
    output logic              core_intr,
    output logic              core_nmi,
    output logic [VEC_W-1:0]  core_vector,
    input  logic              core_ack
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic [ID_W-1:0]  unit_id;
    logic [VEC_W-1:0] tpr_q;
    logic             ctrl_en;
    logic             cmd_launch, cmd_busy;
    logic [VEC_W-1:0] wr_vec;
    logic [ID_W-1:0]  wr_dest;
    logic             accept;
    logic             top_valid, clr_en, offer;
    logic [VEC_W-1:0] top_vec, clr_vec, offer_vec;

    assign msg_in_ready = 1'b1;
    assign accept = msg_in_valid && ctrl_en &&
                    ((msg_in_dest == unit_id) || (msg_in_dest == BCAST));

    irqu_regs #(.DATA_W(DATA_W), .ID_W(ID_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_vec(msg_out_vector), .cmd_dest(msg_out_dest),
        .cmd_busy(cmd_busy), .reg_rdata(reg_rdata), .unit_id(unit_id),
        .prio(tpr_q), .enable(ctrl_en), .cmd_launch(cmd_launch),
        .wr_vec(wr_vec), .wr_dest(wr_dest)
    );

    irqu_pending #(.VEC_W(VEC_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_en(accept), .set_vec(msg_in_vector),
        .clr_en(clr_en), .clr_vec(clr_vec), .top_valid(top_valid), .top_vec(top_vec)
    );

    irqu_deliver #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_dlv (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_en),
        .prio_class(tpr_q[VEC_W-1 -: CLASS_W]), .top_valid(top_valid),
        .top_vec(top_vec), .core_ack(core_ack), .offer(offer),
        .offer_vec(offer_vec), .clr_en(clr_en), .clr_vec(clr_vec)
    );

    irqu_sender #(.VEC_W(VEC_W), .ID_W(ID_W)) u_snd (
        .clk(clk), .rst_n(rst_n), .launch(cmd_launch), .wr_vec(wr_vec),
        .wr_dest(wr_dest), .out_ready(msg_out_ready), .out_valid(msg_out_valid),
        .out_vec(msg_out_vector), .out_dest(msg_out_dest), .busy(cmd_busy)
    );

    always_comb begin
        if (ctrl_en) begin
            core_intr   = offer;
            core_nmi    = 1'b0;
            core_vector = offer ? offer_vec : '0;
        end else begin
            core_intr   = pin_intr;
            core_nmi    = pin_nmi;
            core_vector = '0;
        end
    end

endmodule

// File: rtl/irqu_checker.sv
module irqu_checker #(
    parameter int ID_W    = 8,
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [CLASS_W-1:0] tpr_class,
    input logic               core_intr,
    input logic               core_nmi,
    input logic [VEC_W-1:0]   core_vector,
    input logic               core_ack,
    input logic               msg_out_valid,
    input logic               msg_out_ready,
    input logic [ID_W-1:0]    msg_out_dest,
    input logic [VEC_W-1:0]   msg_out_vector
);
    AST_NMI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !core_nmi); // R3

    AST_LEGACY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (core_vector == '0)); // R2

    AST_GATED_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && core_intr && !$past(core_intr))
        |-> (core_vector[VEC_W-1 -: CLASS_W] > $past(tpr_class))); // R5

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && core_intr && !core_ack) ##1 en |-> $stable(core_vector)); // R7

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && core_intr && core_ack) ##1 en |-> !core_intr); // R7

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_out_valid && !msg_out_ready)
        |=> (msg_out_valid && $stable(msg_out_dest) && $stable(msg_out_vector))); // R11

    AST_OUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_out_valid && msg_out_ready) |=> !msg_out_valid); // R9

endmodule

bind core_irq_unit irqu_checker #(.ID_W(ID_W), .VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tpr_class(tpr_q[VEC_W-1 -: CLASS_W]),
    .core_intr(core_intr), .core_nmi(core_nmi), .core_vector(core_vector),
    .core_ack(core_ack), .msg_out_valid(msg_out_valid), .msg_out_ready(msg_out_ready),
    .msg_out_dest(msg_out_dest), .msg_out_vector(msg_out_vector)
);

// File: tb/tb_core_irq_unit.sv
`timescale 1ns/1ps
module tb_core_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_in_valid = 1'b0;
    logic        msg_in_ready;
    logic [7:0]  msg_in_dest = '0;
    logic [7:0]  msg_in_vector = '0;
    logic        msg_out_valid;
    logic        msg_out_ready = 1'b0;
    logic [7:0]  msg_out_dest, msg_out_vector;
    logic        pin_intr = 1'b0, pin_nmi = 1'b0;
    logic        core_intr, core_nmi;
    logic [7:0]  core_vector;
    logic        core_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    core_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_in_valid(msg_in_valid),
        .msg_in_ready(msg_in_ready), .msg_in_dest(msg_in_dest),
        .msg_in_vector(msg_in_vector), .msg_out_valid(msg_out_valid),
        .msg_out_ready(msg_out_ready), .msg_out_dest(msg_out_dest),
        .msg_out_vector(msg_out_vector), .pin_intr(pin_intr), .pin_nmi(pin_nmi),
        .core_intr(core_intr), .core_nmi(core_nmi), .core_vector(core_vector),
        .core_ack(core_ack)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_pend[256];
    bit m_en, m_off, m_busy;
    int m_id, m_tpr, m_cvec, m_cdest, m_offvec;

    always @(posedge clk or negedge rst_n) begin
        bit en0, launched;
        int id0, tpr0, best;
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 1'b0;
            m_en = 0; m_off = 0; m_busy = 0;
            m_id = 0; m_tpr = 0; m_cvec = 0; m_cdest = 0; m_offvec = 0;
        end else begin
            en0 = m_en; id0 = m_id; tpr0 = m_tpr; best = -1; launched = 0;
            for (int i = 0; i < 256; i++) if (m_pend[i]) best = i;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_id  = int'(reg_wdata[7:0]);
                    2'd1: m_tpr = int'(reg_wdata[7:0]);
                    2'd2: m_en  = reg_wdata[0];
                    default: if (!m_busy) begin
                        m_cvec = int'(reg_wdata[7:0]);
                        m_cdest = int'(reg_wdata[15:8]);
                        launched = 1;
                    end
                endcase
            end
            if (m_busy && msg_out_ready) m_busy = 0;
            if (launched) m_busy = 1;
            if (!en0) m_off = 0;
            else if (m_off) begin
                if (core_ack) begin m_pend[m_offvec] = 0; m_off = 0; end
            end else if (best >= 0 && (best >> 4) > (tpr0 >> 4)) begin
                m_off = 1; m_offvec = best;
            end
            if (msg_in_valid && en0 && (int'(msg_in_dest) == id0 || msg_in_dest == 8'hFF))
                m_pend[msg_in_vector] = 1;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (rst_n && !done) begin
            case (reg_addr)
                2'd0: exp_rd = 32'(m_id);
                2'd1: exp_rd = 32'(m_tpr);
                2'd2: exp_rd = 32'(m_en);
                default: exp_rd = {15'd0, m_busy, 8'(m_cdest), 8'(m_cvec)};
            endcase
            chk("R7 core_intr", 32'(core_intr), 32'(m_en ? m_off : pin_intr));
            chk("R3 core_nmi", 32'(core_nmi), 32'(m_en ? 1'b0 : pin_nmi));
            chk("R6 core_vector", 32'(core_vector), (m_en && m_off) ? 32'(m_offvec) : 32'd0);
            chk("R8 reg_rdata", reg_rdata, exp_rd);
            chk("R9 msg_out_valid", 32'(msg_out_valid), 32'(m_busy));
            chk("R9 msg_out_fields", {16'd0, msg_out_dest, msg_out_vector},
                {16'd0, 8'(m_cdest), 8'(m_cvec)});
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic send(logic [7:0] dest, logic [7:0] vec);
        msg_in_valid = 1'b1; msg_in_dest = dest; msg_in_vector = vec;
        tick();
        msg_in_valid = 1'b0;
    endtask

    task automatic ack();
        core_ack = 1'b1;
        tick();
        core_ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1 chk("R1 reset register", reg_rdata, 32'd0);
        end
        chk("R1 reset msg_out_valid", 32'(msg_out_valid), 32'd0);
        chk("R1 reset core_intr", 32'(core_intr), 32'd0);
        // R2 legacy pass-through
        pin_intr = 1'b1;
        #1 chk("R2 legacy intr", 32'(core_intr), 32'd1);
        pin_nmi = 1'b1;
        #1 chk("R2 legacy nmi", 32'(core_nmi), 32'd1);
        chk("R2 legacy vector", 32'(core_vector), 32'd0);
        pin_intr = 1'b0; pin_nmi = 1'b0;
        tick();
        send(8'h00, 8'h80);
        wr(2'd0, 32'h5); wr(2'd1, 32'h30); wr(2'd2, 32'h1);
        repeat (3) tick();
        chk("R2 message dropped in legacy", 32'(core_intr), 32'd0);
        // R3 pins ignored
        pin_intr = 1'b1; pin_nmi = 1'b1;
        #1 chk("R3 pin intr ignored", 32'(core_intr), 32'd0);
        chk("R3 pin nmi ignored", 32'(core_nmi), 32'd0);
        pin_intr = 1'b0; pin_nmi = 1'b0;
        // R8 read back
        reg_addr = 2'd0; #1 chk("R8 id read", reg_rdata, 32'h5);
        reg_addr = 2'd1; #1 chk("R8 prio read", reg_rdata, 32'h30);
        reg_addr = 2'd2; #1 chk("R8 ctrl read", reg_rdata, 32'h1);
        // R4 destination filtering
        send(8'h07, 8'h90);
        repeat (3) tick();
        chk("R4 foreign dest dropped", 32'(core_intr), 32'd0);
        send(8'h05, 8'h20);
        repeat (3) tick();
        chk("R5 low class gated", 32'(core_intr), 32'd0);
        send(8'hFF, 8'h45);
        tick();
        #1 chk("R4 broadcast offered", 32'(core_intr), 32'd1);
        chk("R4 broadcast vector", 32'(core_vector), 32'h45);
        repeat (3) tick();
        chk("R7 vector held", 32'(core_vector), 32'h45);
        ack();
        chk("R7 drop after ack", 32'(core_intr), 32'd0);
        tick();
        chk("R5 still gated", 32'(core_intr), 32'd0);
        // R6 ordering
        wr(2'd1, 32'hF0);
        send(8'h05, 8'h50); send(8'h05, 8'h71); send(8'hFF, 8'hA0);
        tick();
        chk("R5 all gated by high priority", 32'(core_intr), 32'd0);
        wr(2'd1, 32'h30);
        tick();
        chk("R6 first highest", 32'(core_vector), 32'hA0);
        ack(); tick();
        chk("R6 second", 32'(core_vector), 32'h71);
        ack(); tick();
        chk("R6 third", 32'(core_vector), 32'h50);
        ack(); tick();
        chk("R5 class 2 under class 3", 32'(core_intr), 32'd0);
        wr(2'd1, 32'h00);
        tick();
        chk("R5 released after lowering", 32'(core_vector), 32'h20);
        ack(); tick();
        // R9 / R10 outgoing message
        msg_out_ready = 1'b0;
        wr(2'd3, 32'h0000_0233);
        chk("R9 valid raised", 32'(msg_out_valid), 32'd1);
        chk("R9 fields", {16'd0, msg_out_dest, msg_out_vector}, 32'h0233);
        reg_addr = 2'd3;
        #1 chk("R9 busy reads 1", reg_rdata, 32'h0001_0233);
        wr(2'd3, 32'h0000_0577);
        tick();
        chk("R10 write while busy ignored", {16'd0, msg_out_dest, msg_out_vector}, 32'h0233);
        msg_out_ready = 1'b1;
        tick();
        msg_out_ready = 1'b0;
        chk("R9 valid cleared", 32'(msg_out_valid), 32'd0);
        reg_addr = 2'd3;
        #1 chk("R9 busy reads 0", reg_rdata, 32'h0000_0233);
        // disable while an offer is up, pending survives
        send(8'h05, 8'hB0);
        tick();
        chk("R7 offer B0", 32'(core_vector), 32'hB0);
        wr(2'd2, 32'h0);
        #1 chk("R2 legacy after disable", 32'(core_intr), 32'd0);
        chk("R2 vector zero after disable", 32'(core_vector), 32'd0);
        wr(2'd2, 32'h1);
        tick();
        chk("R7 pending kept over disable", 32'(core_vector), 32'hB0);
        ack();
        repeat (3) tick();
        finish_run();
    end

endmodule